// File: doc/BRIEF.md
# Dual-Compare Interval Timer

This block is a 16-bit up-counter that advances once every eight system clocks. It holds two compare values. Each one raises its own interrupt request when the count steps onto that value. Software reaches the block through a byte-wide register bus. That bus gives access to the two compare values, a control register, a clear-mode register, a request-flag register and a read-only view of the count.

Only the second compare channel can act as a period source. With the clear-mode option on, the step that matches compare 1 returns the count to zero, so the timer repeats with a period of compare-1 ticks. Without that option the count runs to its maximum, wraps to zero and sets a sticky overflow bit in the control register.

Stopping the timer forces both the count and the divide-by-8 prescaler to zero. Each request flag is cleared by its own acknowledge strobe or by a write to the flag register.

Top module: `ivl_timer16`

## Requirements
- R1: After reset the clear-mode register reads 0x10. The control register, both compare registers, the count and both requests read 0.
- R2: While control bit 3 is 1, the count rises by one every 8 clocks. The first step lands on the 8th rising edge after the edge that wrote bit 3 to 1.
- R3: A control write with bit 3 at 0 forces the count to 0 at that edge. It also restarts the prescaler, and the count stays 0 while the timer is stopped.
- R4: When a count step lands on the compare-0 value, request 0 (flag register bit 4) is set and output irq0 rises. A compare value of 0 is never matched by a step.
- R5: When a count step lands on the compare-1 value, request 1 (flag register bit 5) is set and output irq1 rises.
- R6: With clear-mode bit 3 set, the step that matches compare 1 loads 0 into the count instead of the matched value. With compare 1 at 0 and this option on, the count holds at 0 and no request 1 is raised.
- R7: A step that wraps the count from 0xFFFF to 0 sets control bit 2 (overflow). The bit stays set until a control write loads a 0 into bit 2.
- R8: A high pulse on ack0 or ack1 clears request 0 or request 1. A write to the flag register loads both requests from data bits 4 and 5. A match in the same cycle wins over either.
- R9: Address map:
  - 0 and 1: compare-0 low and high byte.
  - 2 and 3: compare-1 low and high byte.
  - 4: clear-mode register.
  - 5: control register.
  - 6: flag register.
  - 7 and 8: read-only count, low then high byte.

  Control bits other than 3 and 2 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| ack0 | input | 1 | Acknowledge, clears request 0 |
| ack1 | input | 1 | Acknowledge, clears request 1 |
| irq0 | output | 1 | Compare-0 interrupt request |
| irq1 | output | 1 | Compare-1 interrupt request |

## Verification
The bench samples one clock before and one clock after the 8th edge following an enable. A prescaler that ran during the stop, or one that took its first step early or late, misses one of those two samples.

The period-clear test watches the match step of compare 1 directly. A design that cleared one tick late would show the compare value in the count for one tick, and one that ignored the clear would keep counting. A compare value of zero with clear on must hold the count at 0 without raising a request; a magnitude-style compare would raise the request on every tick.

Random compare pairs with the clear option switched on and off test three cases:
- compare 0 sits beyond the period and must never fire;
- the two compare values are equal and both must fire;
- the count must equal the number of ticks modulo the period.

A reduced-width instance reaches its wrap quickly. On that instance the bench checks that the overflow bit is set on the wrap, that it survives further ticks, and that only a control write clears it.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int BYTE_W       = 8;
  localparam int CTL_EN_BIT   = 3;
  localparam int CTL_OVF_BIT  = 2;
  localparam int CLR_CMP1_BIT = 3;
  localparam int REQ0_BIT     = 4;
  localparam int REQ1_BIT     = 5;
  localparam logic [BYTE_W-1:0] CLR_MODE_RST = 8'h10;

  // register map, derived from the number of bytes in one count value
  function automatic int map_cmp0(input int nb);
    return 0;
  endfunction
  function automatic int map_cmp1(input int nb);
    return nb;
  endfunction
  function automatic int map_clr(input int nb);
    return 2 * nb;
  endfunction
  function automatic int map_ctl(input int nb);
    return 2 * nb + 1;
  endfunction
  function automatic int map_flg(input int nb);
    return 2 * nb + 2;
  endfunction
  function automatic int map_cnt(input int nb);
    return 2 * nb + 3;
  endfunction
endpackage

// File: rtl/ivt_rst_sync.sv
module ivt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ivt_prescale.sv
module ivt_prescale #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             stop,
  output logic             tick,
  output logic [PRE_W-1:0] phase
);
  localparam logic [PRE_W-1:0] LAST = {PRE_W{1'b1}};

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] phase_d;

  always_comb begin
    if (run && !stop) phase_d = phase_q + 1'b1;
    else              phase_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign tick  = run && (phase_q == LAST);
  assign phase = phase_q;
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             stop,
  input  logic             tick,
  input  logic             clr_on_cmp1,
  input  logic [CNT_W-1:0] cmp0,
  input  logic [CNT_W-1:0] cmp1,
  output logic [CNT_W-1:0] count,
  output logic             hit0,
  output logic             hit1,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   step;

  assign step = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    hit0  = 1'b0;
    hit1  = 1'b0;
    wrap  = 1'b0;
    if (stop || !run) begin
      cnt_d = '0;
    end else if (tick) begin
      if (clr_on_cmp1 && (cmp1 == '0)) begin
        cnt_d = '0;
      end else begin
        hit0  = (step == {1'b0, cmp0});
        hit1  = (step == {1'b0, cmp1});
        wrap  = step[CNT_W];
        cnt_d = (clr_on_cmp1 && hit1) ? '0 : step[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              ack0,
  input  logic              ack1,
  input  logic              hit0,
  input  logic              hit1,
  input  logic              wrap,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  cmp0,
  output logic [CNT_W-1:0]  cmp1,
  output logic              run,
  output logic              stop,
  output logic              ctl_wr,
  output logic              flg_wr,
  output logic              clr_on_cmp1,
  output logic              ovf,
  output logic              req0,
  output logic              req1
);
  localparam int NB    = CNT_W / BYTE_W;
  localparam int A_C0  = map_cmp0(NB);
  localparam int A_C1  = map_cmp1(NB);
  localparam int A_CLR = map_clr(NB);
  localparam int A_CTL = map_ctl(NB);
  localparam int A_FLG = map_flg(NB);
  localparam int A_CNT = map_cnt(NB);

  logic              clr_wr;
  logic [BYTE_W-1:0] clr_q, clr_d;
  logic              en_q, en_d;
  logic              ovf_q, ovf_d;
  logic              r0_q, r0_d;
  logic              r1_q, r1_d;

  assign ctl_wr = reg_wr && (reg_addr == ADDR_W'(A_CTL));
  assign flg_wr = reg_wr && (reg_addr == ADDR_W'(A_FLG));
  assign clr_wr = reg_wr && (reg_addr == ADDR_W'(A_CLR));
  assign stop   = ctl_wr && !reg_wdata[CTL_EN_BIT];

  // compare registers, one byte lane at a time
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic             w0, w1;
    logic [BYTE_W-1:0] c0_q, c0_d, c1_q, c1_d;
    assign w0 = reg_wr && (reg_addr == ADDR_W'(A_C0 + g));
    assign w1 = reg_wr && (reg_addr == ADDR_W'(A_C1 + g));
    always_comb begin
      c0_d = w0 ? reg_wdata : c0_q;
      c1_d = w1 ? reg_wdata : c1_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c0_q <= '0;
        c1_q <= '0;
      end else begin
        c0_q <= c0_d;
        c1_q <= c1_d;
      end
    end
    assign cmp0[g*BYTE_W +: BYTE_W] = c0_q;
    assign cmp1[g*BYTE_W +: BYTE_W] = c1_q;
  end

  // control, clear mode and request flags
  always_comb begin
    clr_d = clr_wr ? reg_wdata : clr_q;
    en_d  = ctl_wr ? reg_wdata[CTL_EN_BIT] : en_q;
    ovf_d = ctl_wr ? reg_wdata[CTL_OVF_BIT] : ovf_q;
    if (wrap) ovf_d = 1'b1;
    r0_d = r0_q;
    r1_d = r1_q;
    if (flg_wr) begin
      r0_d = reg_wdata[REQ0_BIT];
      r1_d = reg_wdata[REQ1_BIT];
    end
    if (ack0) r0_d = 1'b0;
    if (ack1) r1_d = 1'b0;
    if (hit0) r0_d = 1'b1;
    if (hit1) r1_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= CLR_MODE_RST;
      en_q  <= 1'b0;
      ovf_q <= 1'b0;
      r0_q  <= 1'b0;
      r1_q  <= 1'b0;
    end else begin
      clr_q <= clr_d;
      en_q  <= en_d;
      ovf_q <= ovf_d;
      r0_q  <= r0_d;
      r1_q  <= r1_d;
    end
  end

  // read multiplexer
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NB; i++) begin
      if (reg_addr == ADDR_W'(A_C0 + i))  reg_rdata = cmp0[i*BYTE_W +: BYTE_W];
      if (reg_addr == ADDR_W'(A_C1 + i))  reg_rdata = cmp1[i*BYTE_W +: BYTE_W];
      if (reg_addr == ADDR_W'(A_CNT + i)) reg_rdata = count[i*BYTE_W +: BYTE_W];
    end
    if (reg_addr == ADDR_W'(A_CLR)) reg_rdata = clr_q;
    if (reg_addr == ADDR_W'(A_CTL)) begin
      reg_rdata[CTL_EN_BIT]  = en_q;
      reg_rdata[CTL_OVF_BIT] = ovf_q;
    end
    if (reg_addr == ADDR_W'(A_FLG)) begin
      reg_rdata[REQ0_BIT] = r0_q;
      reg_rdata[REQ1_BIT] = r1_q;
    end
  end

  assign run         = en_q;
  assign ovf         = ovf_q;
  assign req0        = r0_q;
  assign req1        = r1_q;
  assign clr_on_cmp1 = clr_q[CLR_CMP1_BIT];
endmodule

// File: rtl/ivl_timer16.sv
module ivl_timer16
  import ivt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ack0,
  input  logic              ack1,
  output logic              irq0,
  output logic              irq1
);
  logic             rst_sync_n;
  logic             run, stop, tick, ctl_wr, flg_wr, clr_on_cmp1;
  logic             hit0, hit1, wrap, ovf;
  logic [PRE_W-1:0] phase;
  logic [CNT_W-1:0] count, cmp0, cmp1;

  ivt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ivt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .stop  (stop),
    .tick  (tick),
    .phase (phase)
  );

  ivt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .run         (run),
    .stop        (stop),
    .tick        (tick),
    .clr_on_cmp1 (clr_on_cmp1),
    .cmp0        (cmp0),
    .cmp1        (cmp1),
    .count       (count),
    .hit0        (hit0),
    .hit1        (hit1),
    .wrap        (wrap)
  );

  ivt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .ack0        (ack0),
    .ack1        (ack1),
    .hit0        (hit0),
    .hit1        (hit1),
    .wrap        (wrap),
    .count       (count),
    .cmp0        (cmp0),
    .cmp1        (cmp1),
    .run         (run),
    .stop        (stop),
    .ctl_wr      (ctl_wr),
    .flg_wr      (flg_wr),
    .clr_on_cmp1 (clr_on_cmp1),
    .ovf         (ovf),
    .req0        (irq0),
    .req1        (irq1)
  );
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             stop,
  input logic             tick,
  input logic             ctl_wr,
  input logic             flg_wr,
  input logic             clr_on_cmp1,
  input logic             ovf,
  input logic             irq1,
  input logic [PRE_W-1:0] phase,
  input logic [CNT_W-1:0] count
);
  // R3
  pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> phase == '0);

  // R3
  cnt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> count == '0);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !stop) |=> $stable(count));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop) |=> (count == $past(count) + 1'b1) || (count == '0));

  // R6
  clr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq1) && $past(clr_on_cmp1) && !$past(flg_wr)) |-> count == '0);

  // R7
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf) && !$past(ctl_wr)) |-> count == '0);
endmodule

bind ivl_timer16 ivt_timer_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .run         (run),
  .stop        (stop),
  .tick        (tick),
  .ctl_wr      (ctl_wr),
  .flg_wr      (flg_wr),
  .clr_on_cmp1 (clr_on_cmp1),
  .ovf         (ovf),
  .irq1        (irq1),
  .phase       (phase),
  .count       (count)
);

// File: tb/ivl_timer16_bench.sv
module ivl_timer16_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_a = 1'b0, wr_b = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       ack0 = 1'b0, ack1 = 1'b0;
  logic [7:0] rdata_a, rdata_b;
  logic       irq0_a, irq1_a, irq0_b, irq1_b;
  int         tests = 0, fails = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  ivl_timer16 u_ivl_timer16 (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_a), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata_a), .ack0(ack0), .ack1(ack1),
    .irq0(irq0_a), .irq1(irq1_a));

  // narrow instance, used to reach the wrap quickly
  ivl_timer16 #(.CNT_W(8)) u_narrow (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_b), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata_b), .ack0(1'b0), .ack1(1'b0),
    .irq0(irq0_b), .irq1(irq1_b));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit narrow, input int a, input int d);
    @(negedge clk);
    addr  = 4'(a);
    wdata = 8'(d);
    if (narrow) wr_b = 1'b1; else wr_a = 1'b1;
    @(negedge clk);
    wr_a = 1'b0;
    wr_b = 1'b0;
  endtask

  task automatic rd(input bit narrow, input int a, output int v);
    addr = 4'(a);
    #1;
    v = narrow ? int'(rdata_b) : int'(rdata_a);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_count(input int ticks, input bit clr, input int per);
    return clr ? (ticks % per) : ticks;
  endfunction

  function automatic bit exp_req0(input int c0, input int c1, input bit clr);
    return !(clr && (c1 < c0));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v;
    v = $urandom(32'h5EED);
    step(3);
    rst_n = 1'b1;
    step(4);

    // reset state
    rd(0, 4, v); chk("R1 clear-mode", v, 8'h10);
    rd(0, 5, v); chk("R1 control", v, 0);
    rd(0, 7, v); chk("R1 count", v, 0);
    rd(0, 0, v); chk("R1 compare0", v, 0);
    chk("R1 irq0", irq0_a, 0);
    chk("R1 irq1", irq1_a, 0);
    rd(1, 2, v); chk("R1 narrow clear-mode", v, 8'h10);

    // prescaler and compare 0
    wr(0, 0, 3); wr(0, 1, 0);
    rd(0, 0, v); chk("R9 compare0 low readback", v, 3);
    wr(0, 5, 8'h08);
    step(7); rd(0, 7, v); chk("R2 count before 8th edge", v, 0);
    step(1); rd(0, 7, v); chk("R2 count at 8th edge", v, 1);
    step(15); chk("R4 irq0 before match", irq0_a, 0);
    step(1);  chk("R4 irq0 at match", irq0_a, 1);
    rd(0, 7, v); chk("R4 count at match", v, 3);

    // acknowledge
    @(negedge clk); ack0 = 1'b1;
    @(negedge clk); ack0 = 1'b0;
    chk("R8 ack0 clears", irq0_a, 0);

    // stop
    wr(0, 5, 8'h00);
    rd(0, 7, v); chk("R3 count zero on stop", v, 0);
    step(20); rd(0, 7, v); chk("R3 count held while stopped", v, 0);

    // period clear on compare 1
    wr(0, 0, 8'h50); wr(0, 2, 4); wr(0, 3, 0); wr(0, 4, 8'h18);
    wr(0, 5, 8'h08);
    step(31); rd(0, 7, v); chk("R6 count before clear", v, 3);
    chk("R5 irq1 before match", irq1_a, 0);
    step(1); rd(0, 7, v); chk("R6 count cleared on match", v, 0);
    chk("R5 irq1 at match", irq1_a, 1);
    step(8); rd(0, 7, v); chk("R6 count after clear", v, 1);

    // flag register writes
    wr(0, 6, 8'h00);
    chk("R8 write clears irq1", irq1_a, 0);
    wr(0, 6, 8'h30);
    chk("R8 write sets irq0", irq0_a, 1);
    chk("R8 write sets irq1", irq1_a, 1);
    wr(0, 6, 8'h00);
    chk("R8 write clears irq0", irq0_a, 0);

    // compare 1 zero with clear on
    wr(0, 5, 0); wr(0, 2, 0); wr(0, 5, 8'h08);
    step(40); rd(0, 7, v); chk("R6 zero period holds count", v, 0);
    chk("R6 zero period no request", irq1_a, 0);

    // high-byte compare, clear off
    wr(0, 5, 0); wr(0, 4, 8'h10); wr(0, 0, 0); wr(0, 1, 1);
    wr(0, 5, 8'h08);
    step(2047);
    rd(0, 7, v); chk("R9 count low byte", v, 8'hFF);
    rd(0, 8, v); chk("R9 count high byte", v, 0);
    chk("R4 irq0 before wide match", irq0_a, 0);
    step(1);
    rd(0, 8, v); chk("R9 count high byte carries", v, 1);
    chk("R4 irq0 at wide match", irq0_a, 1);

    // unused control bits
    wr(0, 5, 8'hF3);
    rd(0, 5, v); chk("R9 control masks unused bits", v, 0);

    // random compare pairs
    for (int it = 0; it < 8; it++) begin
      int c0, c1, m;
      bit cl;
      c0 = $urandom_range(1, 40);
      c1 = $urandom_range(1, 40);
      cl = 1'($urandom_range(0, 1));
      m  = (c0 > c1) ? c0 : c1;
      wr(0, 5, 0); wr(0, 6, 0);
      wr(0, 0, c0); wr(0, 1, 0); wr(0, 2, c1); wr(0, 3, 0);
      wr(0, 4, cl ? 8'h18 : 8'h10);
      wr(0, 5, 8'h08);
      step(8 * m);
      chk("R4 random irq0", irq0_a, exp_req0(c0, c1, cl));
      chk("R5 random irq1", irq1_a, 1);
      rd(0, 7, v); chk("R6 random count", v, exp_count(m, cl, c1));
    end

    // overflow on narrow instance: control at 3, count at 5
    wr(1, 3, 8'h08);
    step(2047);
    rd(1, 3, v); chk("R7 no overflow before wrap", v, 8'h08);
    rd(1, 5, v); chk("R7 count at top", v, 8'hFF);
    step(1);
    rd(1, 3, v); chk("R7 overflow on wrap", v, 8'h0C);
    rd(1, 5, v); chk("R7 count wrapped", v, 0);
    step(8);
    rd(1, 3, v); chk("R7 overflow sticky", v, 8'h0C);
    wr(1, 3, 8'h08);
    rd(1, 3, v); chk("R7 overflow cleared by write", v, 8'h08);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule